// File: doc/BRIEF.md
# CAN Node Error Confinement Controller

This block tracks how healthy a CAN node is on the bus. It keeps a transmit error counter and a receive error counter. It moves the node between three confinement levels: error active, error passive and bus-off. The protocol engine reports events to it as one-cycle strobes: a bit error while sending, an error while receiving, and a successful transmission or reception. It also supplies the sampled bus level together with a tick marking each bit time. From that bit stream the block finds stuffing violations on its own while a frame is in progress, and each one counts as a receive error.

A node in bus-off must not take part in traffic, so the node-enable output is low. Leaving bus-off uses one of two paths. In the automatic path the block first waits a programmable number of clock cycles. In the software path it waits until the init input drops. After that it watches the bus until it has seen 129 runs of 11 consecutive recessive bits. The node then becomes error active again with both counters at zero.

The state machine has four states. `FC_ACTIVE` and `FC_PASSIVE` are the normal operating levels. `FC_OFF_WAIT` is bus-off before recovery begins. `FC_OFF_RECOVER` is bus-off while the recessive runs are being counted. The transitions are:
- active ↔ passive, decided by the thresholds;
- active or passive → wait, when the transmit count goes past 255;
- wait → recover, on the delay expiring or the init release;
- recover → active, on the 129th run.

Top module: `can_fault_conf`

## Requirements
- R1: After reset `state_o` is 00 (error active), `tec_o` and `rec_o` are 0 and `node_en_o` is 1.
- R2: `state_o` encodes error active as 00, error passive as 01 and bus-off as 10. While not in bus-off, the state registered one clock after given counter values is passive if either counter is above 127, and active otherwise.
- R3: When the transmit counter is above 255 in a non-bus-off state, the next clock enters bus-off (`state_o` = 10, `node_en_o` = 0). While in bus-off, every event strobe and stuff error leaves both counters unchanged.
- R4: A `tx_err_i` strobe adds 8 to the transmit counter, and it wins over a simultaneous `tx_ok_i`. A lone `tx_ok_i` subtracts 1, but never below 0.
- R5: A `rx_err_i` strobe or a stuff error adds 1 to the receive counter, saturating at 255, and it wins over a simultaneous `rx_ok_i`. A lone `rx_ok_i` subtracts 1, but never below 0.
- R6: While `frame_active_i` is high and the node is not in bus-off, the sixth consecutive tick carrying the same bus level raises `stuff_err_o` in that same cycle. The run count then restarts at zero. A change of level, or `frame_active_i` low, also restarts it.
- R7: With `auto_recover_i` = 1, the node stays in the bus-off wait phase for `recover_delay_i` + 1 clock cycles before it starts counting recessive runs.
- R8: With `auto_recover_i` = 0, the wait phase lasts until `init_i` is seen at 1 on one clock and at 0 on the next. Recessive bits seen before that are not counted.
- R9: During recovery, a tick with `bus_bit_i` = 1 (recessive) extends the current run. A tick with `bus_bit_i` = 0 restarts the current run without losing completed runs. On the clock edge of the tick that completes the 129th run of 11 bits, the node returns to 00 with both counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| frame_active_i | input | 1 | High while a frame is on the bus (enables stuff checking) |
| tx_err_i | input | 1 | Bit error detected while transmitting |
| tx_ok_i | input | 1 | Frame transmitted successfully |
| rx_err_i | input | 1 | Error detected while receiving |
| rx_ok_i | input | 1 | Frame received successfully |
| auto_recover_i | input | 1 | 1 = automatic recovery after the delay, 0 = wait for init release |
| recover_delay_i | input | DLY_W | Clock cycles to wait before automatic recovery |
| init_i | input | 1 | Software init bit; its release starts manual recovery |
| state_o | output | 2 | Confinement state code |
| tec_o | output | TEC_W | Transmit error counter |
| rec_o | output | REC_W | Receive error counter |
| node_en_o | output | 1 | Low while in bus-off |
| stuff_err_o | output | 1 | Stuff violation detected this cycle |

## Verification
Some properties are checked by the assertions on every cycle:
- the +8 transmit step and the zero floor on the receive counter;
- the one-clock entry into passive and into bus-off;
- counters frozen through bus-off;
- the stuff and run counters staying below their limits;
- a dominant bit clearing only the current run;
- the wait phase holding without an init release;
- the counter clear on leaving recovery.

Only the bench scenarios can show the rest: the exact length of the automatic delay, the full 1419-bit recovery with a dominant bit inside it, the sixth-bit position of a stuff error, and the return from passive to active once the counts fall.

// File: rtl/canfc_pkg.sv
package canfc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE      = 2'd0,
        FC_PASSIVE     = 2'd1,
        FC_OFF_WAIT    = 2'd2,
        FC_OFF_RECOVER = 2'd3
    } fc_state_e;

    localparam logic [1:0] CODE_ACTIVE  = 2'b00;
    localparam logic [1:0] CODE_PASSIVE = 2'b01;
    localparam logic [1:0] CODE_BUS_OFF = 2'b10;

endpackage

// File: rtl/canfc_err_counters.sv
module canfc_err_counters #(
    parameter int TEC_W   = 9,
    parameter int REC_W   = 8,
    parameter int TX_STEP = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic             clear_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o
);

    localparam logic [TEC_W-1:0] TEC_MAX  = '1;
    localparam logic [REC_W-1:0] REC_MAX  = '1;
    localparam logic [TEC_W-1:0] TEC_STEP = TEC_W'(TX_STEP);

    logic [TEC_W-1:0] tec_q, tec_d;
    logic [REC_W-1:0] rec_q, rec_d;

    always_comb begin
        tec_d = tec_q;
        if (clear_i) begin
            tec_d = '0;
        end else if (!hold_i) begin
            if (tx_err_i) begin
                tec_d = (tec_q > TEC_MAX - TEC_STEP) ? TEC_MAX : tec_q + TEC_STEP;
            end else if (tx_ok_i && tec_q != '0) begin
                tec_d = tec_q - 1'b1;
            end
        end
    end

    always_comb begin
        rec_d = rec_q;
        if (clear_i) begin
            rec_d = '0;
        end else if (!hold_i) begin
            if (rx_err_i) begin
                rec_d = (rec_q == REC_MAX) ? REC_MAX : rec_q + 1'b1;
            end else if (rx_ok_i && rec_q != '0) begin
                rec_d = rec_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tec_q <= '0;
            rec_q <= '0;
        end else begin
            tec_q <= tec_d;
            rec_q <= rec_d;
        end
    end

    assign tec_o = tec_q;
    assign rec_o = rec_q;

    AST_TEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && !clear_i && tx_err_i && tec_q <= TEC_MAX - TEC_STEP)
        |=> (tec_q == $past(tec_q) + TEC_STEP)); // R4

    AST_REC_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !rx_err_i && rec_q == '0) |=> (rec_q == '0)); // R5

endmodule

// File: rtl/canfc_stuff_mon.sv
module canfc_stuff_mon #(
    parameter int STUFF_LEN = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic bit_i,
    input  logic frame_i,
    input  logic enable_i,
    output logic err_o
);

    localparam int LEN_W = $clog2(STUFF_LEN);
    localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(STUFF_LEN - 1);

    logic [LEN_W-1:0] len_q, len_d;
    logic             last_q, last_d;

    assign err_o = tick_i && frame_i && enable_i && (bit_i == last_q) && (len_q == LEN_LAST);

    always_comb begin
        len_d  = len_q;
        last_d = tick_i ? bit_i : last_q;
        if (!frame_i || !enable_i) begin
            len_d = '0;
        end else if (tick_i) begin
            if (err_o) begin
                len_d = '0;
            end else if (bit_i == last_q) begin
                len_d = len_q + 1'b1;
            end else begin
                len_d = LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            len_q  <= '0;
            last_q <= 1'b1;
        end else begin
            len_q  <= len_d;
            last_q <= last_d;
        end
    end

    AST_STUFF_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (len_q <= LEN_LAST)); // R6

    AST_STUFF_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> (len_q == '0)); // R6

endmodule

// File: rtl/canfc_recovery.sv
module canfc_recovery #(
    parameter int DLY_W     = 16,
    parameter int RUN_LEN   = 11,
    parameter int RUN_TOTAL = 129
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wait_i,
    input  logic             count_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             tick_i,
    input  logic             bit_i,
    output logic             delay_done_o,
    output logic             done_o
);

    localparam int RUN_W  = $clog2(RUN_LEN);
    localparam int RUNS_W = $clog2(RUN_TOTAL);
    localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(RUN_LEN - 1);
    localparam logic [RUNS_W-1:0] RUNS_LAST = RUNS_W'(RUN_TOTAL - 1);
    localparam logic [DLY_W-1:0]  DLY_MAX   = '1;

    logic [DLY_W-1:0]  dly_q, dly_d;
    logic [RUN_W-1:0]  run_q, run_d;
    logic [RUNS_W-1:0] runs_q, runs_d;

    assign delay_done_o = wait_i && (dly_q >= delay_i);
    assign done_o       = count_i && tick_i && bit_i && (run_q == RUN_LAST) && (runs_q == RUNS_LAST);

    always_comb begin
        if (!wait_i) begin
            dly_d = '0;
        end else if (dly_q == DLY_MAX) begin
            dly_d = dly_q;
        end else begin
            dly_d = dly_q + 1'b1;
        end
    end

    always_comb begin
        run_d  = run_q;
        runs_d = runs_q;
        if (!count_i) begin
            run_d  = '0;
            runs_d = '0;
        end else if (tick_i) begin
            if (!bit_i) begin
                run_d = '0;
            end else if (run_q == RUN_LAST) begin
                run_d  = '0;
                runs_d = (runs_q == RUNS_LAST) ? '0 : runs_q + 1'b1;
            end else begin
                run_d = run_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dly_q  <= '0;
            run_q  <= '0;
            runs_q <= '0;
        end else begin
            dly_q  <= dly_d;
            run_q  <= run_d;
            runs_q <= runs_d;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q <= RUN_LAST)); // R9

    AST_DOMINANT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_i && tick_i && !bit_i) |=> (run_q == '0 && runs_q == $past(runs_q))); // R9

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int DLY_W         = 16,
    parameter int TX_STEP       = 8,
    parameter int PASSIVE_LIMIT = 127,
    parameter int OFF_LIMIT     = 255,
    parameter int STUFF_LEN     = 6,
    parameter int RUN_LEN       = 11,
    parameter int RUN_TOTAL     = 129
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bit_tick_i,
    input  logic             bus_bit_i,
    input  logic             frame_active_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    input  logic             auto_recover_i,
    input  logic [DLY_W-1:0] recover_delay_i,
    input  logic             init_i,
    output logic [1:0]       state_o,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic             node_en_o,
    output logic             stuff_err_o
);

    import canfc_pkg::*;

    localparam logic [TEC_W-1:0] TEC_PASS_LIM = TEC_W'(PASSIVE_LIMIT);
    localparam logic [REC_W-1:0] REC_PASS_LIM = REC_W'(PASSIVE_LIMIT);
    localparam logic [TEC_W-1:0] TEC_OFF_LIM  = TEC_W'(OFF_LIMIT);

    fc_state_e        state_q, state_d;
    logic             init_q;
    logic             init_fall;
    logic [TEC_W-1:0] tec_w;
    logic [REC_W-1:0] rec_w;
    logic             in_bus_off;
    logic             in_wait;
    logic             in_recover;
    logic             stuff_w;
    logic             delay_done;
    logic             rec_done;
    logic             cnt_clear;

    assign init_fall = init_q && !init_i;

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= FC_ACTIVE;
            init_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            init_q  <= init_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE, FC_PASSIVE: begin
                if (tec_w > TEC_OFF_LIM) begin
                    state_d = FC_OFF_WAIT;
                end else if (tec_w > TEC_PASS_LIM || rec_w > REC_PASS_LIM) begin
                    state_d = FC_PASSIVE;
                end else begin
                    state_d = FC_ACTIVE;
                end
            end
            FC_OFF_WAIT: begin
                if (auto_recover_i ? delay_done : init_fall) begin
                    state_d = FC_OFF_RECOVER;
                end
            end
            FC_OFF_RECOVER: begin
                if (rec_done) begin
                    state_d = FC_ACTIVE;
                end
            end
        endcase
    end

    // Outputs and control derived from the state
    always_comb begin
        in_wait    = 1'b0;
        in_recover = 1'b0;
        state_o    = CODE_ACTIVE;
        unique case (state_q)
            FC_ACTIVE:      state_o = CODE_ACTIVE;
            FC_PASSIVE:     state_o = CODE_PASSIVE;
            FC_OFF_WAIT: begin
                state_o = CODE_BUS_OFF;
                in_wait = 1'b1;
            end
            FC_OFF_RECOVER: begin
                state_o    = CODE_BUS_OFF;
                in_recover = 1'b1;
            end
        endcase
        in_bus_off  = in_wait || in_recover;
        node_en_o   = !in_bus_off;
        cnt_clear   = in_recover && rec_done;
        stuff_err_o = stuff_w;
        tec_o       = tec_w;
        rec_o       = rec_w;
    end

    canfc_err_counters #(
        .TEC_W   (TEC_W),
        .REC_W   (REC_W),
        .TX_STEP (TX_STEP)
    ) u_counters (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hold_i   (in_bus_off),
        .clear_i  (cnt_clear),
        .tx_err_i (tx_err_i),
        .tx_ok_i  (tx_ok_i),
        .rx_err_i (rx_err_i || stuff_w),
        .rx_ok_i  (rx_ok_i),
        .tec_o    (tec_w),
        .rec_o    (rec_w)
    );

    canfc_stuff_mon #(
        .STUFF_LEN (STUFF_LEN)
    ) u_stuff (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (bit_tick_i),
        .bit_i    (bus_bit_i),
        .frame_i  (frame_active_i),
        .enable_i (!in_bus_off),
        .err_o    (stuff_w)
    );

    canfc_recovery #(
        .DLY_W     (DLY_W),
        .RUN_LEN   (RUN_LEN),
        .RUN_TOTAL (RUN_TOTAL)
    ) u_recovery (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wait_i       (in_wait),
        .count_i      (in_recover),
        .delay_i      (recover_delay_i),
        .tick_i       (bit_tick_i),
        .bit_i        (bus_bit_i),
        .delay_done_o (delay_done),
        .done_o       (rec_done)
    );

    AST_PASSIVE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == FC_ACTIVE || state_q == FC_PASSIVE) && tec_w <= TEC_OFF_LIM
         && (tec_w > TEC_PASS_LIM || rec_w > REC_PASS_LIM))
        |=> (state_o == CODE_PASSIVE)); // R2

    AST_BUSOFF_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == FC_ACTIVE || state_q == FC_PASSIVE) && tec_w > TEC_OFF_LIM)
        |=> (state_o == CODE_BUS_OFF && !node_en_o)); // R3

    AST_BUSOFF_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FC_OFF_WAIT || (state_q == FC_OFF_RECOVER && !rec_done))
        |=> ($stable(tec_o) && $stable(rec_o))); // R3

    AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FC_OFF_WAIT && !auto_recover_i && !init_fall)
        |=> (state_q == FC_OFF_WAIT)); // R8

    AST_RECOVERY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FC_OFF_RECOVER && rec_done)
        |=> (tec_o == '0 && rec_o == '0 && state_o == CODE_ACTIVE)); // R9

endmodule

// File: tb/can_fault_conf_tb_top.sv
module can_fault_conf_tb_top;

    localparam int DLY_W    = 16;
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             bus = 1'b1;
    logic             frame = 1'b0;
    logic             tx_err = 1'b0;
    logic             tx_ok = 1'b0;
    logic             rx_err = 1'b0;
    logic             rx_ok = 1'b0;
    logic             auto_en = 1'b0;
    logic [DLY_W-1:0] dly = '0;
    logic             init = 1'b0;
    logic [1:0]       state;
    logic [8:0]       tec;
    logic [7:0]       rec;
    logic             node_en;
    logic             stuff;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    can_fault_conf dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .bit_tick_i      (tick),
        .bus_bit_i       (bus),
        .frame_active_i  (frame),
        .tx_err_i        (tx_err),
        .tx_ok_i         (tx_ok),
        .rx_err_i        (rx_err),
        .rx_ok_i         (rx_ok),
        .auto_recover_i  (auto_en),
        .recover_delay_i (dly),
        .init_i          (init),
        .state_o         (state),
        .tec_o           (tec),
        .rec_o           (rec),
        .node_en_o       (node_en),
        .stuff_err_o     (stuff)
    );

    // Behavioural reference model: 0 active, 1 passive, 2 off waiting, 3 off recovering
    int m_state, m_tec, m_rec, m_dly, m_run, m_runs, m_len, m_last, m_initp;
    int o_tec, o_rec, o_state, o_dly;
    bit m_boff, m_stf, m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_tec = 0; m_rec = 0; m_dly = 0;
            m_run = 0; m_runs = 0; m_len = 0; m_last = 1; m_initp = 0;
        end else begin
            o_tec = m_tec; o_rec = m_rec; o_state = m_state; o_dly = m_dly;
            m_boff = (m_state >= 2);
            m_stf  = !m_boff && tick && frame && (int'(bus) == m_last) && (m_len == 5);
            m_done = (m_state == 3) && tick && bus && (m_run == 10) && (m_runs == 128);
            if (m_done) begin
                m_tec = 0; m_rec = 0;
            end else if (!m_boff) begin
                if (tx_err) m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
                else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
                if (rx_err || m_stf) m_rec = (m_rec == 255) ? 255 : m_rec + 1;
                else if (rx_ok && m_rec > 0) m_rec = m_rec - 1;
            end
            if (!frame || m_boff) m_len = 0;
            else if (tick) m_len = m_stf ? 0 : ((int'(bus) == m_last) ? m_len + 1 : 1);
            if (tick) m_last = int'(bus);
            if (m_state == 3) begin
                if (tick) begin
                    if (!bus) m_run = 0;
                    else if (m_run == 10) begin
                        m_run = 0;
                        m_runs = (m_runs == 128) ? 0 : m_runs + 1;
                    end else m_run = m_run + 1;
                end
            end else begin
                m_run = 0; m_runs = 0;
            end
            m_dly = (o_state == 2) ? ((o_dly == 65535) ? o_dly : o_dly + 1) : 0;
            case (o_state)
                0, 1: m_state = (o_tec > 255) ? 2 : ((o_tec > 127 || o_rec > 127) ? 1 : 0);
                2: if (auto_en ? (o_dly >= int'(dly)) : (m_initp != 0 && !init)) m_state = 3;
                3: if (m_done) m_state = 0;
                default: m_state = 0;
            endcase
            m_initp = int'(init);
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 R3 state code", int'(state), (m_state >= 2) ? 2 : m_state);
            chk("R4 tec", int'(tec), m_tec);
            chk("R5 rec", int'(rec), m_rec);
            chk("R3 node enable", int'(node_en), (m_state >= 2) ? 0 : 1);
            chk("R6 stuff flag", int'(stuff),
                ((m_state < 2) && tick && frame && (int'(bus) == m_last) && (m_len == 5)) ? 1 : 0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic pulse_tx_err(input int n);
        for (int i = 0; i < n; i++) begin
            tx_err = 1'b1; step(1); tx_err = 1'b0;
        end
    endtask

    task automatic pulse_rx_err(input int n);
        for (int i = 0; i < n; i++) begin
            rx_err = 1'b1; step(1); rx_err = 1'b0;
        end
    endtask

    task automatic pulse_rx_ok(input int n);
        for (int i = 0; i < n; i++) begin
            rx_ok = 1'b1; step(1); rx_ok = 1'b0;
        end
    endtask

    task automatic send_bits(input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; bus = b; step(1);
        end
        tick = 1'b0; bus = 1'b1;
    endtask

    task automatic summary;
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int off_cycles;
        step(3);
        @(negedge clk);
        chk("R1 reset state", int'(state), 0);
        chk("R1 reset tec", int'(tec), 0);
        chk("R1 reset rec", int'(rec), 0);
        chk("R1 reset node enable", int'(node_en), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(2);

        // Floors at zero
        pulse_rx_ok(3);
        tx_ok = 1'b1; step(1); tx_ok = 1'b0;
        @(negedge clk);
        chk("R5 rx_ok floor", int'(rec), 0);
        chk("R4 tx_ok floor", int'(tec), 0);
        @(posedge clk); #1;

        // Receive errors into passive, then back out
        pulse_rx_err(128);
        step(1);
        @(negedge clk);
        chk("R5 rec after 128 errors", int'(rec), 128);
        chk("R2 passive from rec", int'(state), 1);
        @(posedge clk); #1;
        rx_err = 1'b1; rx_ok = 1'b1; step(1); rx_err = 1'b0; rx_ok = 1'b0;
        @(negedge clk);
        chk("R5 rx_err wins over rx_ok", int'(rec), 129);
        @(posedge clk); #1;
        pulse_rx_ok(2);
        step(1);
        @(negedge clk);
        chk("R2 back to active", int'(state), 0);
        @(posedge clk); #1;
        pulse_rx_ok(127);

        // Stuff detection: five equal bits then a change is fine; six equal flags
        frame = 1'b1;
        send_bits(1'b1, 5);
        send_bits(1'b0, 5);
        tick = 1'b1; bus = 1'b0;
        @(negedge clk);
        chk("R6 sixth equal bit flags", int'(stuff), 1);
        @(posedge clk); #1;
        tick = 1'b0; bus = 1'b1;
        @(negedge clk);
        chk("R6 stuff counts as receive error", int'(rec), 1);
        @(posedge clk); #1;
        send_bits(1'b0, 5);
        frame = 1'b0;
        step(1);
        pulse_rx_ok(1);

        // Transmit errors into passive and bus-off
        pulse_tx_err(16);
        step(1);
        @(negedge clk);
        chk("R4 tec after 16 bit errors", int'(tec), 128);
        chk("R2 passive from tec", int'(state), 1);
        @(posedge clk); #1;
        tx_err = 1'b1; tx_ok = 1'b1; step(1); tx_err = 1'b0; tx_ok = 1'b0;
        @(negedge clk);
        chk("R4 tx_err wins over tx_ok", int'(tec), 136);
        @(posedge clk); #1;
        pulse_tx_err(16);
        step(1);
        @(negedge clk);
        chk("R3 bus-off code", int'(state), 2);
        chk("R3 node disabled", int'(node_en), 0);
        @(posedge clk); #1;
        pulse_tx_err(2);
        pulse_rx_err(2);
        pulse_rx_ok(1);
        @(negedge clk);
        chk("R3 tec frozen in bus-off", int'(tec), 264);
        chk("R3 rec frozen in bus-off", int'(rec), 0);
        @(posedge clk); #1;

        // Software path: recessive bus does nothing until init is released
        send_bits(1'b1, 1500);
        @(negedge clk);
        chk("R8 no recovery without init release", int'(state), 2);
        @(posedge clk); #1;
        init = 1'b1; step(3);
        init = 1'b0; step(2);
        send_bits(1'b1, 5);
        send_bits(1'b0, 1);
        send_bits(1'b1, 129 * 11 - 1);
        @(negedge clk);
        chk("R9 still bus-off before final bit", int'(state), 2);
        @(posedge clk); #1;
        send_bits(1'b1, 1);
        @(negedge clk);
        chk("R9 active after 129 runs", int'(state), 0);
        chk("R9 tec cleared", int'(tec), 0);
        @(posedge clk); #1;

        // Automatic path with a programmed delay
        auto_en = 1'b1;
        dly = 16'd20;
        pulse_tx_err(33);
        tick = 1'b1; bus = 1'b1;
        off_cycles = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (state == 2'b10) off_cycles++;
            else if (off_cycles > 0) break;
            @(posedge clk); #1;
        end
        tick = 1'b0;
        chk("R7 bus-off length with delay", off_cycles, 20 + 1 + 129 * 11);
        chk("R7 counters cleared", int'(tec) + int'(rec), 0);
        step(3);
        summary();
    end

endmodule